// File: doc/BRIEF.md
# RGMII to GMII bridge

This block sits between a byte-wide GMII-style MAC interface and the reduced-pin RGMII pads. On the transmit side it takes a data byte, an enable and an error flag on each rising edge of the transmit clock. It drives a 4-bit pad bus and a single control pad, with both pads used on both clock phases. On the receive side it samples the 4-bit pad bus and the control pad on both edges of the clock recovered by the PHY. It rebuilds a data byte, a valid flag and an error flag, and realigns them into the receive clock domain.

Three speeds are supported. At 1000 Mb/s the pads carry a whole byte per clock, one nibble on each edge. At 10 and 100 Mb/s the pads carry one nibble per clock, and the internal bus uses only its low nibble. The control pad is time-multiplexed at every speed: enable or valid in the high phase, and that flag XOR error in the low phase. The double-rate pad registers are modelled as rising-edge and falling-edge flops followed by a clock-level output mux. The transmit clock is forwarded to the clock pad unchanged.

Top module: `rgmii_gmii_bridge`

## Requirements
- R1: With speed_i = 2'b10 (1000 Mb/s), after the rising edge that samples a byte b, rgmii_txd_o shows b[3:0] while tx_clk_i is high. In the following low phase it shows b[7:4].
- R2: With speed_i at 2'b00 or 2'b01 (10/100 Mb/s), rgmii_txd_o shows b[3:0] through both phases of the cycle after the sampling edge, and gmii_txd_i[7:4] has no effect on the pads.
- R3: rgmii_txctl_o shows the sampled gmii_tx_en_i while tx_clk_i is high. In the following low phase it shows gmii_tx_en_i XOR gmii_tx_er_i.
- R4: Transmit latency is fixed: inputs sampled at rising edge k appear on the pads from edge k through the low phase ending at edge k+1.
- R5: At 1000 Mb/s, the nibble sampled at rising edge k of rx_clk_i forms gmii_rxd_o[3:0] and the nibble sampled at the next falling edge forms gmii_rxd_o[7:4]. The byte is presented from rising edge k+1, one cycle of latency.
- R6: At 10/100 Mb/s, gmii_rxd_o carries the rising-edge nibble in bits 3:0 with bits 7:4 zero, and the falling-edge nibble has no effect.
- R7: gmii_rx_dv_o equals the control pad sampled at the rising edge. gmii_rx_er_o equals that sample XOR the falling-edge sample. Both have the same one-cycle latency as the data.
- R8: While rst_ni is low, rgmii_txd_o and rgmii_txctl_o are 0 in both clock phases, and gmii_rxd_o, gmii_rx_dv_o and gmii_rx_er_o are 0.
- R9: Speed code 2'b11 is treated as a nibble-per-clock speed, the same as 2'b00 and 2'b01.
- R10: rgmii_txc_o follows tx_clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk_i | input | 1 | Transmit clock (2.5/25/125 MHz) |
| rx_clk_i | input | 1 | Receive clock recovered by the PHY |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed_i | input | 2 | 00: 10 Mb/s, 01: 100 Mb/s, 10: 1000 Mb/s, 11: nibble mode |
| gmii_txd_i | input | 8 | Transmit byte (low nibble only at 10/100) |
| gmii_tx_en_i | input | 1 | Transmit enable |
| gmii_tx_er_i | input | 1 | Transmit error |
| rgmii_txc_o | output | 1 | Forwarded transmit clock pad |
| rgmii_txd_o | output | 4 | Transmit nibble pad bus |
| rgmii_txctl_o | output | 1 | Transmit control pad |
| rgmii_rxd_i | input | 4 | Receive nibble pad bus |
| rgmii_rxctl_i | input | 1 | Receive control pad |
| gmii_rxd_o | output | 8 | Rebuilt receive byte |
| gmii_rx_dv_o | output | 1 | Receive data valid |
| gmii_rx_er_o | output | 1 | Receive error |

## Verification
The hardest behaviour to reach from the ports is the falling-edge content of each cycle. A bench that only samples after rising edges sees neither the transmit high nibble nor the enable-XOR-error phase. It also cannot make the receive side see a falling-edge value different from the rising-edge one. The stimulus therefore changes the receive pads between the two edges of every cycle, putting the high nibble and the XORed control on the pads only for the falling edge. It checks each transmit byte twice, once in the high phase and once in the low phase. Random bytes, flags and speed codes are mixed with directed error-only, error-with-enable and reserved-speed cases. In nibble mode the receive pads carry the inverted low nibble for the falling edge, so that a leak of the falling-edge sample into the rebuilt byte shows up.

// File: rtl/rgmii_bridge_pkg.sv
package rgmii_bridge_pkg;
  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  function automatic logic is_gig(input logic [1:0] spd);
    return spd == SPD_1000;
  endfunction
endpackage

// File: rtl/rgmii_tx_ddr.sv
module rgmii_tx_ddr #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              en_i,
  input  logic              er_i,
  output logic [NIB_W-1:0]  pad_d_o,
  output logic              pad_ctl_o
);
  logic [BYTE_W-1:0] hold_d;
  logic              hold_en, hold_er, hold_gig;
  logic [NIB_W-1:0]  fall_d;
  logic              fall_ctl;

  // speed captured with the byte so both phases agree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_d   <= '0;
      hold_en  <= 1'b0;
      hold_er  <= 1'b0;
      hold_gig <= 1'b0;
    end else begin
      hold_d   <= data_i;
      hold_en  <= en_i;
      hold_er  <= er_i;
      hold_gig <= gig_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_d   <= '0;
      fall_ctl <= 1'b0;
    end else begin
      fall_d   <= hold_gig ? hold_d[BYTE_W-1:NIB_W] : hold_d[NIB_W-1:0];
      fall_ctl <= hold_en ^ hold_er;
    end
  end

  // behavioural DDR output: high phase from rise flops, low phase from fall flops
  assign pad_d_o   = clk_i ? hold_d[NIB_W-1:0] : fall_d;
  assign pad_ctl_o = clk_i ? hold_en : fall_ctl;
endmodule

// File: rtl/rgmii_rx_ddr.sv
module rgmii_rx_ddr #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gig_i,
  input  logic [NIB_W-1:0]  pad_d_i,
  input  logic              pad_ctl_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              dv_o,
  output logic              er_o
);
  logic [NIB_W-1:0] rise_d, fall_d;
  logic             rise_c, fall_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_d <= '0;
      rise_c <= 1'b0;
    end else begin
      rise_d <= pad_d_i;
      rise_c <= pad_ctl_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_d <= '0;
      fall_c <= 1'b0;
    end else begin
      fall_d <= pad_d_i;
      fall_c <= pad_ctl_i;
    end
  end

  // realign both half-cycle samples into one rising-edge word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      dv_o   <= 1'b0;
      er_o   <= 1'b0;
    end else begin
      data_o <= gig_i ? {fall_d, rise_d} : {{NIB_W{1'b0}}, rise_d};
      dv_o   <= rise_c;
      er_o   <= rise_c ^ fall_c;
    end
  end
endmodule

// File: rtl/rgmii_gmii_bridge.sv
module rgmii_gmii_bridge
  import rgmii_bridge_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input  logic              tx_clk_i,
  input  logic              rx_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        speed_i,
  input  logic [BYTE_W-1:0] gmii_txd_i,
  input  logic              gmii_tx_en_i,
  input  logic              gmii_tx_er_i,
  output logic              rgmii_txc_o,
  output logic [NIB_W-1:0]  rgmii_txd_o,
  output logic              rgmii_txctl_o,
  input  logic [NIB_W-1:0]  rgmii_rxd_i,
  input  logic              rgmii_rxctl_i,
  output logic [BYTE_W-1:0] gmii_rxd_o,
  output logic              gmii_rx_dv_o,
  output logic              gmii_rx_er_o
);
  logic gig;
  assign gig         = is_gig(speed_i);
  assign rgmii_txc_o = tx_clk_i;

  rgmii_tx_ddr #(.BYTE_W(BYTE_W)) u_tx (
    .clk_i    (tx_clk_i),
    .rst_ni   (rst_ni),
    .gig_i    (gig),
    .data_i   (gmii_txd_i),
    .en_i     (gmii_tx_en_i),
    .er_i     (gmii_tx_er_i),
    .pad_d_o  (rgmii_txd_o),
    .pad_ctl_o(rgmii_txctl_o)
  );

  rgmii_rx_ddr #(.BYTE_W(BYTE_W)) u_rx (
    .clk_i    (rx_clk_i),
    .rst_ni   (rst_ni),
    .gig_i    (gig),
    .pad_d_i  (rgmii_rxd_i),
    .pad_ctl_i(rgmii_rxctl_i),
    .data_o   (gmii_rxd_o),
    .dv_o     (gmii_rx_dv_o),
    .er_o     (gmii_rx_er_o)
  );
endmodule

// File: rtl/rgmii_gmii_bridge_chk.sv
module rgmii_gmii_bridge_chk #(
  parameter int BYTE_W = 8,
  localparam int NIB_W = BYTE_W / 2
) (
  input logic              tx_clk_i,
  input logic              rx_clk_i,
  input logic              rst_ni,
  input logic [1:0]        speed_i,
  input logic [BYTE_W-1:0] gmii_txd_i,
  input logic              gmii_tx_en_i,
  input logic              gmii_tx_er_i,
  input logic              rgmii_txc_o,
  input logic [NIB_W-1:0]  rgmii_txd_o,
  input logic              rgmii_txctl_o,
  input logic [NIB_W-1:0]  rgmii_rxd_i,
  input logic              rgmii_rxctl_i,
  input logic [BYTE_W-1:0] gmii_rxd_o,
  input logic              gmii_rx_dv_o,
  input logic              gmii_rx_er_o
);
  logic [NIB_W-1:0] exp_lo_q;
  logic             exp_en_q, exp_ok_q;

  always_ff @(posedge tx_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_lo_q <= '0;
      exp_en_q <= 1'b0;
      exp_ok_q <= 1'b0;
    end else begin
      exp_lo_q <= gmii_txd_i[NIB_W-1:0];
      exp_en_q <= gmii_tx_en_i;
      exp_ok_q <= 1'b1;
    end
  end

  // R3
  tx_ctl_low_phase_chk: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> rgmii_txctl_o == $past(gmii_tx_en_i ^ gmii_tx_er_i));

  // R1
  tx_hi_nibble_chk: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(speed_i) == 2'b10 |-> rgmii_txd_o == $past(gmii_txd_i[BYTE_W-1:NIB_W]));

  // R2
  tx_nibble_mode_chk: assert property (@(posedge tx_clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(speed_i) != 2'b10 |-> rgmii_txd_o == $past(gmii_txd_i[NIB_W-1:0]));

  // R4
  tx_high_phase_chk: assert property (@(negedge tx_clk_i) disable iff (!rst_ni)
    exp_ok_q |-> rgmii_txctl_o == exp_en_q && rgmii_txd_o == exp_lo_q);

  // R8
  tx_reset_quiet_chk: assert property (@(posedge tx_clk_i)
    !rst_ni && $past(!rst_ni) |-> rgmii_txd_o == '0 && !rgmii_txctl_o);

  // R7
  rx_dv_latency_chk: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(rst_ni, 2) |-> gmii_rx_dv_o == $past(rgmii_rxctl_i, 2));

  // R6
  rx_hi_zero_chk: assert property (@(posedge rx_clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(speed_i) != 2'b10 |-> gmii_rxd_o[BYTE_W-1:NIB_W] == '0);
endmodule

bind rgmii_gmii_bridge rgmii_gmii_bridge_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/rgmii_gmii_bridge_bench.sv
module rgmii_gmii_bridge_bench;
  localparam int CLK_PERIOD = 8;
  localparam int HALF = CLK_PERIOD / 2;

  logic       tx_clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       rst_ni;
  logic [1:0] speed;
  logic [7:0] txd;
  logic       tx_en, tx_er;
  logic       txc;
  logic [3:0] pad_txd;
  logic       pad_txctl;
  logic [3:0] pad_rxd;
  logic       pad_rxctl;
  logic [7:0] rxd;
  logic       rx_dv, rx_er;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(HALF) tx_clk = ~tx_clk;
  initial begin
    #2;
    forever #(HALF) rx_clk = ~rx_clk;
  end

  rgmii_gmii_bridge u_rgmii_gmii_bridge (
    .tx_clk_i     (tx_clk),
    .rx_clk_i     (rx_clk),
    .rst_ni       (rst_ni),
    .speed_i      (speed),
    .gmii_txd_i   (txd),
    .gmii_tx_en_i (tx_en),
    .gmii_tx_er_i (tx_er),
    .rgmii_txc_o  (txc),
    .rgmii_txd_o  (pad_txd),
    .rgmii_txctl_o(pad_txctl),
    .rgmii_rxd_i  (pad_rxd),
    .rgmii_rxctl_i(pad_rxctl),
    .gmii_rxd_o   (rxd),
    .gmii_rx_dv_o (rx_dv),
    .gmii_rx_er_o (rx_er)
  );

  function automatic bit gig_of(input logic [1:0] s);
    return s == 2'b10;
  endfunction

  function automatic logic [3:0] exp_tx_low_phase(input logic [1:0] s, input logic [7:0] b);
    return gig_of(s) ? b[7:4] : b[3:0];
  endfunction

  function automatic logic [7:0] exp_rx_byte(input logic [1:0] s, input logic [3:0] lo,
                                             input logic [3:0] hi);
    return gig_of(s) ? {hi, lo} : {4'h0, lo};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tx_step(input logic [1:0] s, input logic [7:0] b, input logic en,
                         input logic er);
    @(posedge tx_clk);
    #1;
    speed = s; txd = b; tx_en = en; tx_er = er;
    @(posedge tx_clk);
    #2;
    check("R1/R4 high-phase nibble", pad_txd, b[3:0]);
    check("R3 high-phase ctl", pad_txctl, en);
    check("R10 txc high", txc, 1'b1);
    #(HALF);
    if (gig_of(s)) check("R1 low-phase nibble", pad_txd, exp_tx_low_phase(s, b));
    else           check("R2/R9 low-phase nibble", pad_txd, exp_tx_low_phase(s, b));
    check("R3 low-phase ctl", pad_txctl, en ^ er);
    check("R10 txc low", txc, 1'b0);
  endtask

  task automatic rx_step(input logic [1:0] s, input logic [3:0] lo, input logic [3:0] hi,
                         input logic dv, input logic er);
    speed = s;
    @(negedge rx_clk);
    #1;
    pad_rxd = lo; pad_rxctl = dv;
    @(posedge rx_clk);
    #1;
    pad_rxd = gig_of(s) ? hi : ~lo;
    pad_rxctl = dv ^ er;
    @(posedge rx_clk);
    #1;
    if (gig_of(s)) check("R5 rx byte", rxd, exp_rx_byte(s, lo, hi));
    else           check("R6/R9 rx nibble", rxd, exp_rx_byte(s, lo, hi));
    check("R7 rx dv", rx_dv, dv);
    check("R7 rx er", rx_er, er);
  endtask

  task automatic reset_checks();
    @(posedge tx_clk);
    #2;
    check("R8 reset txd high phase", pad_txd, 4'h0);
    check("R8 reset txctl high phase", pad_txctl, 1'b0);
    #(HALF);
    check("R8 reset txd low phase", pad_txd, 4'h0);
    check("R8 reset txctl low phase", pad_txctl, 1'b0);
    check("R8 reset rx outputs", {rxd, rx_dv, rx_er}, 10'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_ni = 1'b0;
    speed = 2'b10; txd = 8'hff; tx_en = 1'b1; tx_er = 1'b1;
    pad_rxd = 4'hf; pad_rxctl = 1'b1;
    repeat (3) @(posedge tx_clk);
    reset_checks();
    #1;
    rst_ni = 1'b1;

    // directed corners
    tx_step(2'b10, 8'ha5, 1'b1, 1'b0);
    tx_step(2'b10, 8'h3c, 1'b0, 1'b1);
    tx_step(2'b10, 8'hf0, 1'b1, 1'b1);
    tx_step(2'b01, 8'hf5, 1'b1, 1'b0);
    tx_step(2'b00, 8'h9a, 1'b0, 1'b0);
    tx_step(2'b11, 8'h7e, 1'b1, 1'b0);
    rx_step(2'b10, 4'h5, 4'ha, 1'b1, 1'b0);
    rx_step(2'b10, 4'hc, 4'h3, 1'b0, 1'b1);
    rx_step(2'b10, 4'h1, 4'he, 1'b1, 1'b1);
    rx_step(2'b01, 4'h6, 4'h0, 1'b1, 1'b0);
    rx_step(2'b11, 4'h9, 4'h0, 1'b1, 1'b1);

    for (int i = 0; i < 200; i++) begin
      tx_step(2'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 200; i++) begin
      rx_step(2'($urandom), 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom));
    end

    // reset in mid-run
    @(posedge tx_clk);
    #1;
    txd = 8'hff; tx_en = 1'b1; tx_er = 1'b0; speed = 2'b10;
    rst_ni = 1'b0;
    reset_checks();
    #1;
    rst_ni = 1'b1;
    tx_step(2'b10, 8'h81, 1'b1, 1'b0);
    rx_step(2'b10, 4'h2, 4'hd, 1'b1, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule